// File: doc/BRIEF.md
# Baud Rate Generator with Periodic Timer Mode

The block is a 16-bit down-counter that sets the pace of a serial receiver. Software loads a period value through two byte-wide registers, one for each half. The counter counts down from that value, reloads itself when it expires, and starts the next period. While the serial receiver is enabled, each expiry produces a one-cycle oversampling tick for the receiver.

A single control bit has two meanings, chosen by the receiver state. With the receiver enabled, the bit selects what the period registers return on a read: the programmed value or the live count. With the receiver disabled, the same bit turns the counter into a free-running periodic timer. In that mode every expiry sets a sticky interrupt flag, which stays set until software clears it.

Reads of the live count are not double-buffered. Reading the two halves on different cycles can therefore return a value that the counter never held.

Top module: `baud_timer`

## Requirements
- R1: The period value is 16 bits, written as a low byte at address 0 and a high byte at address 1. When the control bit (bit 0 at address 2) is 0, or when the receiver is disabled, reads of addresses 0 and 1 return the programmed value.
- R2: The counter decrements once per clock. When it expires (count equal to 1), it reloads the period value N in the same cycle, so expiries are exactly N cycles apart. While rx_en_i is 1, tick_o is high for exactly the expiry cycle.
- R3: A period value of 0 gives a period of 65536 cycles. After reset the count is 0, so the first period is also 65536 cycles long.
- R4: Writing a new period value does not disturb the count in progress. The new value takes effect only at the next expiry.
- R5: While rx_en_i is 1 and the control bit is 1, reads of addresses 0 and 1 return the low and high bytes of the live count.
- R6: Reading the high byte does not capture the low byte. The two halves, read on consecutive cycles across an expiry, can combine into a value the counter never held.
- R7: While rx_en_i is 0 and the control bit is 1, each expiry sets the interrupt flag (irq_o, also readable at address 3 bit 0) and tick_o stays low.
- R8: The interrupt flag is never set while the control bit is 0 or while rx_en_i is 1.
- R9: The interrupt flag is sticky: it stays set until software writes 1 to bit 0 at address 3.
- R10: After reset, all four registers read 0, and tick_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from address) |
| rx_en_i | input | 1 | Serial receiver enabled |
| tick_o | output | 1 | Oversampling tick, one cycle per expiry |
| irq_o | output | 1 | Sticky timer interrupt flag |

## Verification
The hardest case to reach is the torn read. It requires the high-byte read to land on the exact expiry cycle and the low-byte read to land on the cycle after it. The bench drives the address at the falling edge and synchronises to the observed tick, so the high byte is read while the count is 1. The low byte is then read one cycle later, after the reload, and both halves are checked against arithmetic expectations.

The 65536-cycle period of a zero period value is measured from reset. That same measurement also shows that a period value written mid-count leaves the running period untouched.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_IRQ  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // expiry at 1 so a reload of 0 wraps through all 2^CNT_W states
  assign expire_o = (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (expire_o) cnt_q <= reload_i;
    else               cnt_q <= cnt_q - CNT_W'(1);
  end

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == $past(reload_i));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/baud_regs.sv
module baud_regs
  import baud_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic              rx_en_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              sel_o,
  output logic              irq_o
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic sel_q, irq_q, irq_set, irq_clr;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE = ADDR_W'(k);
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     lane_q <= '0;
      else if (we_i && addr_i == LANE) lane_q <= wdata_i;
    end
    assign reload_o[k*BYTE_W +: BYTE_W] = lane_q;
  end

  assign irq_set = expire_i && !rx_en_i && sel_q;
  assign irq_clr = we_i && addr_i == REG_IRQ && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_CTRL) sel_q <= wdata_i[0];
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign sel_o = sel_q;
  assign irq_o = irq_q;

  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !rx_en_i && sel_q) |=> irq_q);
  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !(we_i && addr_i == REG_IRQ && wdata_i[0])) |=> irq_q);
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(expire_i && !rx_en_i && sel_q));
endmodule

// File: rtl/baud_rdmux.sv
module baud_rdmux
  import baud_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sel_i,
  input  logic              rx_en_i,
  input  logic              irq_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] src;
  // no shadow register: each byte reflects the count at its own read cycle
  assign src = (sel_i && rx_en_i) ? cnt_i : reload_i;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NBYTES; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = src[k*BYTE_W +: BYTE_W];
    if (addr_i == REG_CTRL) rdata_o = {{(BYTE_W-1){1'b0}}, sel_i};
    if (addr_i == REG_IRQ)  rdata_o = {{(BYTE_W-1){1'b0}}, irq_i};
  end
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import baud_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        rx_en_i,
  output logic        tick_o,
  output logic        irq_o
);
  logic [CNT_W-1:0] reload, cnt;
  logic             expire, sel;

  baud_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .expire_i(expire), .rx_en_i, .reload_o(reload), .sel_o(sel), .irq_o
  );

  baud_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
  );

  baud_rdmux #(.CNT_W(CNT_W)) u_rd (
    .addr_i, .reload_i(reload), .cnt_i(cnt), .sel_i(sel), .rx_en_i,
    .irq_i(irq_o), .rdata_o
  );

  assign tick_o = expire && rx_en_i;

  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload != CNT_W'(1)) |=> !tick_o);
endmodule

// File: tb/baud_timer_tb.sv
module baud_timer_tb;
  logic clk = 0, rst_n = 0, we = 0, rx_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tick, irq;

  int checks = 0, errors = 0;
  int ncnt = 0, ticks = 0, t_last = 0, t_prev = 0;
  int irq_rises = 0, i_last = 0, i_prev = 0;
  logic irq_d = 0;

  always #5 clk = ~clk;

  baud_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_en_i(rx_en), .tick_o(tick), .irq_o(irq)
  );

  always @(negedge clk) begin
    ncnt++;
    #1;
    if (tick) begin t_prev = t_last; t_last = ncnt; ticks++; end
    if (irq && !irq_d) begin i_prev = i_last; i_last = ncnt; irq_rises++; end
    irq_d = irq;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #2; v = int'(rdata);
  endtask

  task automatic wait_ticks(input int n);
    int tgt = ticks + n;
    wait (ticks >= tgt);
  endtask

  task automatic wait_irq(input int n);
    int tgt = irq_rises + n;
    wait (irq_rises >= tgt);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int v, t0, hi, lo, n0;
    int periods[8] = '{1, 2, 3, 5, 8, 13, 256, 511};
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = 2'(a); #2;
      chk(rdata == 0, "R10 reg reset", int'(rdata), 0);
    end
    chk(!tick && !irq, "R10 outputs reset", int'({tick, irq}), 0);
    @(negedge clk); rst_n = 1; rx_en = 1;

    // R3: first expiry from count 0, then write mid-count (R4)
    wait_ticks(1);
    t0 = ncnt;
    wr(0, 8'd3);
    wait_ticks(1);
    chk(t_last - t_prev == 65536, "R3/R4 zero period undisturbed", t_last - t_prev, 65536);
    wait_ticks(1);
    chk(t_last - t_prev == 3, "R4 new period after expiry", t_last - t_prev, 3);

    // R2 period sweep, R1 readback
    foreach (periods[i]) begin
      wr(0, 8'(periods[i]));
      wr(1, 8'(periods[i] >> 8));
      wait_ticks(2);
      chk(t_last - t_prev == periods[i], "R2 period", t_last - t_prev, periods[i]);
      rd(0, lo); rd(1, hi);
      chk((hi << 8 | lo) == periods[i], "R1 readback", hi << 8 | lo, periods[i]);
    end

    // R5 live count
    wr(0, 8'd5); wr(1, 8'd0); wr(2, 8'd1);
    wait_ticks(2);
    @(negedge clk); addr = 0;
    wait_ticks(1);
    chk(rdata == 1, "R5 live count at expiry", int'(rdata), 1);
    for (int k = 5; k >= 1; k--) begin
      @(negedge clk); #2;
      chk(rdata == 8'(k), "R5 live count", int'(rdata), k);
    end

    // R6 torn read across expiry with period 0x0100
    wr(0, 8'd0); wr(1, 8'd1);
    wait_ticks(2);
    @(negedge clk); addr = 1;
    wait_ticks(1);
    hi = int'(rdata);
    @(negedge clk); addr = 0; #2; lo = int'(rdata);
    chk(hi == 0 && lo == 0, "R6 torn pair", hi << 8 | lo, 0);
    addr = 1; #1;
    chk(rdata == 1, "R6 high after reload", int'(rdata), 1);

    // R7 timer mode, R9 sticky flag
    @(negedge clk); rx_en = 0;
    n0 = ticks;
    wr(0, 8'h40); wr(1, 8'd0); wr(3, 8'd1);
    wait_irq(1);
    repeat (10) @(negedge clk);
    rd(3, v);
    chk(v == 1, "R9 flag sticky", v, 1);
    rd(0, v);
    chk(v == 8'h40, "R1 reload read with rx off", v, 64);
    wr(3, 8'd1);
    rd(3, v);
    chk(v == 0, "R9 flag cleared", v, 0);
    wait_irq(1);
    wr(3, 8'd1);
    wait_irq(1);
    chk(i_last - i_prev == 64, "R7 timer period", i_last - i_prev, 64);
    chk(ticks == n0, "R7 no tick with rx off", ticks - n0, 0);

    // R8 no flag when bit clear or rx on
    wr(2, 8'd0); wr(3, 8'd1);
    repeat (300) @(negedge clk);
    chk(!irq, "R8 no flag with bit clear", int'(irq), 0);
    chk(ticks == n0, "R7 no tick with rx off", ticks - n0, 0);
    @(negedge clk); rx_en = 1;
    wr(2, 8'd1);
    repeat (300) @(negedge clk);
    chk(!irq, "R8 no flag with rx on", int'(irq), 0);
    chk(ticks - n0 >= 4, "R2 ticks resume", ticks - n0, 4);
    finish_run();
  end
endmodule